// File: doc/BRIEF.md
# Spatial Dither Bit-Depth Reducer

This stage sits on a pixel stream and narrows each of the three 12-bit colour components to 6, 8 or 10 significant bits. When dithering is active, it adds pseudo-random noise below the lowest kept bit before it cuts the low bits. The noise comes from one 28-bit linear feedback shift register (LFSR) per channel. A plain truncation path with no noise covers the case where dithering is off. The output stays MSB-aligned on 12 bits, and the dropped bits read as zero.

Configuration is captured on a one-cycle load strobe. The load also seeds the three LFSRs, and it forces dithering off for that cycle and for the next one. Options choose between one shared feedback polynomial and three distinct per-channel polynomials, turn on reseeding at every frame start, and swap the raw noise for a high-pass version. In the high-pass version the noise is the difference between consecutive LFSR samples. In frame-random mode, a small frame counter perturbs the reseed value so that successive frames start from different points of the sequence.

Top module: `dither_reducer`

## Requirements
- R1: Depth code 0 keeps 6 bits, code 1 keeps 8, code 2 keeps 10, and code 3 keeps all 12. The output is the 12-bit component with the dropped low bits forced to zero.
- R2: A dithered component equals input plus noise, saturated at 4095, with the dropped bits then cleared. An input of 4095 therefore never wraps.
- R3: With the per-channel option off, every channel steps as s' = {s[26:0], s[27]^s[2]}. Its noise is s[11:0] masked to the dropped bits. Each LFSR advances once per valid pixel while dithering is active, and holds otherwise.
- R4: With the per-channel option on, R uses feedback s[27]^s[2], G uses s[27]^s[8], and B uses s[27]^s[12].
- R5: The load strobe writes each channel's seed into its LFSR. A zero seed is replaced by 1.
- R6: With frame-random on, a valid pixel marked frame-start takes its noise from a fresh state, seed XOR swapped counter in bits [3:0], and the sequence continues from there. With frame-random off, only the load reseeds. Line-start markers never alter the sequence. A frame-start pixel must also carry line-start.
- R7: The frame counter starts at 0 on load and steps on each reseeding frame-start. For depth codes 0 and 1 it wraps after 15, and its four bits are used in reversed order. For code 2 it wraps after 3, and its two bits are used reversed in bits [1:0]. For code 3 the swapped value is 0.
- R8: In the load cycle and the cycle after it, no noise is added and the LFSRs do not advance. Pixels follow the truncation rules of R9 with the new configuration.
- R9: Without dithering, the truncation path works as follows. With the 4:2:2 flag set, codes 1 and 2 truncate to 8 and 10 bits and codes 0 and 3 pass through. Otherwise the truncate enable cuts to the R1 width, and with it clear the pixel passes unchanged.
- R10: With high-pass on, the noise is (current[11:0] − previous[11:0]) mod 4096, masked to the dropped bits. The previous sample is the state used by the last advancing pixel, or the seed after a load. On a reseeding frame-start it is the fresh state itself.
- R11: Output data and valid are registered with exactly one cycle of latency, and valid is copied unchanged. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that captures all cfg_* inputs and seeds |
| cfg_dither_en | input | 1 | Enable noise-based reduction |
| cfg_trunc_en | input | 1 | Enable plain truncation when not dithering |
| cfg_422 | input | 1 | Stream is 4:2:2; selects the restricted truncation rule |
| cfg_depth | input | 2 | Target depth code (0:6, 1:8, 2:10, 3:12 bits) |
| cfg_frame_rand | input | 1 | Reseed the LFSRs at each frame start |
| cfg_chan_poly | input | 1 | Use distinct feedback taps per channel |
| cfg_highpass | input | 1 | Use the difference of consecutive LFSR samples as noise |
| cfg_seed_r | input | 28 | Red LFSR seed |
| cfg_seed_g | input | 28 | Green LFSR seed |
| cfg_seed_b | input | 28 | Blue LFSR seed |
| in_valid | input | 1 | Pixel qualifier |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_r | input | 12 | Red component |
| in_g | input | 12 | Green component |
| in_b | input | 12 | Blue component |
| out_valid | output | 1 | Registered copy of in_valid |
| out_r | output | 12 | Reduced red, MSB-aligned |
| out_g | output | 12 | Reduced green, MSB-aligned |
| out_b | output | 12 | Reduced blue, MSB-aligned |

## Verification
The assertions take for granted that a frame-start pixel also carries line-start. They also assume configuration changes reach the block only through the load strobe, which resets the frame counter and so keeps it inside the limit for the current depth. The bench drives every frame start together with line start, asserts the strobe only on cycles without a valid pixel, and keeps the cfg_* inputs otherwise untouched. Random pixels, gaps and frame lengths are generated within those rules. Directed cases cover saturation at full scale, zero seeds, the pixel right after a load, and enough frames to wrap both counter limits.

// File: rtl/dith_pkg.sv
// Package: shared helpers for the spatial dither reducer.
// Assumes a 12-bit class pixel; depth codes map to kept widths 6/8/10/all.
package dith_pkg;

    // Number of low bits removed for a depth code at a given pixel width.
    function automatic int drop_bits(input logic [1:0] code, input int pix_w);
        case (code)
            2'd0:    return pix_w - 6;
            2'd1:    return pix_w - 8;
            2'd2:    return pix_w - 10;
            default: return 0;
        endcase
    endfunction

    // Alternative feedback tap (1-based exponent) used per channel index.
    function automatic int alt_tap_of(input int ch);
        case (ch)
            0:       return 3;
            1:       return 9;
            default: return 13;
        endcase
    endfunction

endpackage

// File: rtl/dith_lfsr.sv
// Module: one channel's noise source. A Fibonacci LFSR with polynomial
// x^W + x^t + 1, where t is 3 or ALT_TAP per a runtime select.
// Assumes load and adv are never both high (load wins if they are).
module dith_lfsr #(
    parameter int W       = 28,
    parameter int ALT_TAP = 3,
    parameter int NOISE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [W-1:0]       seed,
    input  logic [W-1:0]       reseed,
    input  logic               use_reseed,
    input  logic               adv,
    input  logic               alt_tap,
    input  logic               highpass,
    output logic [NOISE_W-1:0] noise
);
    logic [W-1:0] state, prev, used, prev_eff, nxt;
    logic         fb;

    function automatic logic [W-1:0] nz(input logic [W-1:0] v);
        return (v == '0) ? W'(1) : v;
    endfunction

    // State used by this pixel, and the sample it is differenced against.
    always_comb begin
        used     = use_reseed ? nz(reseed) : state;
        prev_eff = use_reseed ? used : prev;
        fb       = used[W-1] ^ (alt_tap ? used[ALT_TAP-1] : used[2]);
        nxt      = {used[W-2:0], fb};
        noise    = highpass ? (used[NOISE_W-1:0] - prev_eff[NOISE_W-1:0])
                            : used[NOISE_W-1:0];
    end

    // Seed on load, step once per advancing pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W'(1);
            prev  <= W'(1);
        end else if (load) begin
            state <= nz(seed);
            prev  <= nz(seed);
        end else if (adv) begin
            state <= nxt;
            prev  <= used;
        end
    end

    p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
    p_lfsr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(state));
endmodule

// File: rtl/dith_frame_ctr.sv
// Module: frame counter for frame-random reseeding. Wraps after 15 (codes
// 0/1) or 3 (code 2) and presents its bits reversed for the reseed XOR.
// Assumes depth only changes on the same edge as load.
module dith_frame_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [1:0]       depth,
    output logic [CNT_W-1:0] swapped
);
    logic [CNT_W-1:0] cnt, limit;

    // Limit and bit order chosen by depth code.
    always_comb begin
        limit   = '0;
        swapped = '0;
        if (depth <= 2'd1) begin
            limit = '1;
            for (int i = 0; i < CNT_W; i++) swapped[i] = cnt[CNT_W-1-i];
        end else if (depth == 2'd2) begin
            limit      = CNT_W'(3);
            swapped[0] = cnt[1];
            swapped[1] = cnt[0];
        end
    end

    // Count reseeding frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n || load) cnt <= '0;
        else if (tick)      cnt <= (cnt >= limit) ? '0 : cnt + 1'b1;
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);
endmodule

// File: rtl/dith_lane.sv
// Module: one colour lane, combinational. Adds masked noise below the kept
// LSB, saturates at full scale, then clears the dropped bits.
module dith_lane #(
    parameter int PIX_W = 12,
    parameter int DW    = 4
) (
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] noise,
    input  logic [DW-1:0]    drop,
    input  logic             add_en,
    output logic [PIX_W-1:0] q
);
    logic [PIX_W-1:0] keep_mask, n;
    logic [PIX_W:0]   sum;

    // Add, saturate, truncate.
    always_comb begin
        keep_mask = {PIX_W{1'b1}} << drop;
        n         = add_en ? (noise & ~keep_mask) : '0;
        sum       = {1'b0, pix} + {1'b0, n};
        q         = (sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0]) & keep_mask;
    end
endmodule

// File: rtl/dither_reducer.sv
// Module: top of the spatial dither reducer. Captures configuration on
// cfg_load, runs three LFSR lanes and registers the result one cycle later.
// Assumes cfg_load is not asserted together with a valid pixel of interest
// and that every frame-start pixel is also a line-start pixel.
module dither_reducer #(
    parameter int PIX_W  = 12,
    parameter int LFSR_W = 28,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_dither_en,
    input  logic              cfg_trunc_en,
    input  logic              cfg_422,
    input  logic [1:0]        cfg_depth,
    input  logic              cfg_frame_rand,
    input  logic              cfg_chan_poly,
    input  logic              cfg_highpass,
    input  logic [LFSR_W-1:0] cfg_seed_r,
    input  logic [LFSR_W-1:0] cfg_seed_g,
    input  logic [LFSR_W-1:0] cfg_seed_b,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);
    localparam int NCH = 3;
    localparam int DW  = $clog2(PIX_W + 1);

    logic                          q_en, q_trunc, q_422, q_fr, q_pc, q_hp;
    logic [1:0]                    q_depth;
    logic [NCH-1:0][LFSR_W-1:0]    q_seed;
    logic                          dith_on, noise_on, use_rs, adv, started;
    logic [CNT_W-1:0]              swap_v;
    logic [DW-1:0]                 drop_d, drop_t, drop_sel;
    logic [NCH-1:0][PIX_W-1:0]     pix_in, lane_q, out_q, noise;

    assign pix_in = {in_b, in_g, in_r};

    // Capture configuration on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {q_en, q_trunc, q_422, q_fr, q_pc, q_hp} <= '0;
            q_depth <= '0;
            q_seed  <= '0;
        end else if (cfg_load) begin
            q_en    <= cfg_dither_en;
            q_trunc <= cfg_trunc_en;
            q_422   <= cfg_422;
            q_fr    <= cfg_frame_rand;
            q_pc    <= cfg_chan_poly;
            q_hp    <= cfg_highpass;
            q_depth <= cfg_depth;
            q_seed  <= {cfg_seed_b, cfg_seed_g, cfg_seed_r};
        end
    end

    // Dithering is held off through the load cycle and the one after it.
    always_ff @(posedge clk) begin
        if (!rst_n) dith_on <= 1'b0;
        else        dith_on <= cfg_load ? 1'b0 : q_en;
    end

    // Noise gating, reseed and drop-width selection.
    always_comb begin
        noise_on = dith_on & ~cfg_load;
        adv      = in_valid & noise_on;
        use_rs   = adv & in_sof & q_fr;
        drop_d   = DW'(dith_pkg::drop_bits(q_depth, PIX_W));
        if (q_422)        drop_t = (q_depth == 2'd1 || q_depth == 2'd2) ? drop_d : '0;
        else if (q_trunc) drop_t = drop_d;
        else              drop_t = '0;
        drop_sel = noise_on ? drop_d : drop_t;
    end

    dith_frame_ctr #(.CNT_W(CNT_W)) u_fctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .tick    (use_rs),
        .depth   (q_depth),
        .swapped (swap_v)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dith_lfsr #(
            .W       (LFSR_W),
            .ALT_TAP (dith_pkg::alt_tap_of(c)),
            .NOISE_W (PIX_W)
        ) u_lfsr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (cfg_load),
            .seed       (c == 0 ? cfg_seed_r : (c == 1 ? cfg_seed_g : cfg_seed_b)),
            .reseed     (q_seed[c] ^ LFSR_W'(swap_v)),
            .use_reseed (use_rs),
            .adv        (adv),
            .alt_tap    (q_pc),
            .highpass   (q_hp),
            .noise      (noise[c])
        );
        dith_lane #(.PIX_W(PIX_W), .DW(DW)) u_lane (
            .pix    (pix_in[c]),
            .noise  (noise[c]),
            .drop   (drop_sel),
            .add_en (noise_on),
            .q      (lane_q[c])
        );
    end

    // Output register, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_q     <= '0;
            started   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_q     <= lane_q;
            started   <= 1'b1;
        end
    end

    assign out_r = out_q[0];
    assign out_g = out_q[1];
    assign out_b = out_q[2];

    p_valid_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (out_valid == $past(in_valid)));
    p_load_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !dith_on);
    p_sof_is_sol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |-> in_sol);
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_r == '1) |=> (out_r[PIX_W-1] == 1'b1));
endmodule

// File: tb/dither_reducer_tb.sv
module dither_reducer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 0, cfg_dither_en = 0, cfg_trunc_en = 0, cfg_422 = 0;
    logic [1:0]  cfg_depth = 0;
    logic        cfg_frame_rand = 0, cfg_chan_poly = 0, cfg_highpass = 0;
    logic [27:0] cfg_seed_r = 0, cfg_seed_g = 0, cfg_seed_b = 0;
    logic        in_valid = 0, in_sof = 0, in_sol = 0;
    logic [11:0] in_r = 0, in_g = 0, in_b = 0;
    logic        out_valid;
    logic [11:0] out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;

    // model state
    logic        m_en, m_trunc, m_422, m_fr, m_pc, m_hp, m_on;
    logic [1:0]  m_depth;
    logic [27:0] m_seed [3];
    logic [27:0] m_lfsr [3];
    logic [27:0] m_prev [3];
    logic [3:0]  m_cnt;

    always #2 clk = ~clk;

    dither_reducer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_dither_en(cfg_dither_en),
        .cfg_trunc_en(cfg_trunc_en), .cfg_422(cfg_422), .cfg_depth(cfg_depth),
        .cfg_frame_rand(cfg_frame_rand), .cfg_chan_poly(cfg_chan_poly),
        .cfg_highpass(cfg_highpass), .cfg_seed_r(cfg_seed_r), .cfg_seed_g(cfg_seed_g),
        .cfg_seed_b(cfg_seed_b), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic int drop_of(input logic [1:0] d);
        return (d == 0) ? 6 : (d == 1) ? 4 : (d == 2) ? 2 : 0;
    endfunction

    function automatic logic [27:0] nz(input logic [27:0] v);
        return (v == 0) ? 28'd1 : v;
    endfunction

    function automatic logic [27:0] step(input logic [27:0] s, input int ch, input logic pc);
        int tap;
        tap = pc ? ((ch == 0) ? 3 : (ch == 1) ? 9 : 13) : 3;
        return {s[26:0], s[27] ^ s[tap-1]};
    endfunction

    function automatic logic [3:0] swap_of(input logic [3:0] c, input logic [1:0] d);
        if (d <= 1) return {c[0], c[1], c[2], c[3]};
        if (d == 2) return {2'b00, c[0], c[1]};
        return 4'd0;
    endfunction

    function automatic logic [3:0] limit_of(input logic [1:0] d);
        return (d <= 1) ? 4'd15 : (d == 2) ? 4'd3 : 4'd0;
    endfunction

    function automatic logic [11:0] reduce(input logic [11:0] p, input logic [11:0] n,
                                           input int drop, input logic add);
        logic [11:0] mask;
        logic [12:0] s;
        mask = 12'hFFF << drop;
        s = {1'b0, p} + {1'b0, (add ? (n & ~mask) : 12'd0)};
        return (s[12] ? 12'hFFF : s[11:0]) & mask;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_load(input logic en, tr, c422, input logic [1:0] d,
                           input logic fr, pc, hp,
                           input logic [27:0] sr, sg, sb);
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_sol = 0;
        cfg_load = 1; cfg_dither_en = en; cfg_trunc_en = tr; cfg_422 = c422;
        cfg_depth = d; cfg_frame_rand = fr; cfg_chan_poly = pc; cfg_highpass = hp;
        cfg_seed_r = sr; cfg_seed_g = sg; cfg_seed_b = sb;
        @(posedge clk);
        #1;
        m_en = en; m_trunc = tr; m_422 = c422; m_depth = d;
        m_fr = fr; m_pc = pc; m_hp = hp;
        m_seed[0] = sr; m_seed[1] = sg; m_seed[2] = sb;
        for (int c = 0; c < 3; c++) begin
            m_lfsr[c] = nz(m_seed[c]);
            m_prev[c] = nz(m_seed[c]);
        end
        m_cnt = 0;
        m_on = 0;
    endtask

    task automatic pix(input logic v, sof, sol, input logic [11:0] r, g, b,
                       input string req);
        logic [11:0] exp [3];
        logic [11:0] pin [3];
        logic [27:0] used [3];
        logic [27:0] pe;
        logic [11:0] n;
        logic        rs;
        int          dt;
        @(negedge clk);
        cfg_load = 0;
        in_valid = v; in_sof = sof; in_sol = sol; in_r = r; in_g = g; in_b = b;
        pin[0] = r; pin[1] = g; pin[2] = b;
        rs = v & sof & m_fr & m_on;
        if (m_422) dt = (m_depth == 1 || m_depth == 2) ? drop_of(m_depth) : 0;
        else       dt = m_trunc ? drop_of(m_depth) : 0;
        for (int c = 0; c < 3; c++) begin
            used[c] = rs ? nz(m_seed[c] ^ {24'd0, swap_of(m_cnt, m_depth)}) : m_lfsr[c];
            pe = rs ? used[c] : m_prev[c];
            n = m_hp ? (used[c][11:0] - pe[11:0]) : used[c][11:0];
            if (m_on) exp[c] = reduce(pin[c], n, drop_of(m_depth), 1'b1);
            else      exp[c] = reduce(pin[c], 12'd0, dt, 1'b0);
        end
        @(posedge clk);
        #1;
        check(req, "valid", {11'd0, out_valid}, {11'd0, v});
        if (v) begin
            check(req, "r", out_r, exp[0]);
            check(req, "g", out_g, exp[1]);
            check(req, "b", out_b, exp[2]);
            if (m_on) begin
                for (int c = 0; c < 3; c++) begin
                    m_prev[c] = used[c];
                    m_lfsr[c] = step(used[c], c, m_pc);
                end
                if (rs) m_cnt = (m_cnt >= limit_of(m_depth)) ? 4'd0 : m_cnt + 4'd1;
            end
        end
        m_on = m_en;
    endtask

    // random frames: nf frames of np pixels in lines of 4, with gaps
    task automatic frames(input int nf, input int np, input string req);
        for (int f = 0; f < nf; f++) begin
            for (int p = 0; p < np; p++) begin
                if ($urandom_range(0, 4) == 0) pix(0, 0, 0, 0, 0, 0, req);
                pix(1, p == 0, (p % 4) == 0, 12'($urandom), 12'($urandom),
                    12'($urandom), req);
            end
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_d17));
        m_en = 0; m_trunc = 0; m_422 = 0; m_fr = 0; m_pc = 0; m_hp = 0; m_on = 0;
        m_depth = 0; m_cnt = 0;
        for (int c = 0; c < 3; c++) begin m_seed[c] = 0; m_lfsr[c] = 1; m_prev[c] = 1; end
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check("R11", "reset valid", {11'd0, out_valid}, 12'd0);
        check("R11", "reset r", out_r, 12'd0);
        check("R11", "reset g", out_g, 12'd0);
        check("R11", "reset b", out_b, 12'd0);
        @(negedge clk);
        rst_n = 1;

        // R9 pass-through and truncation
        do_load(0, 0, 0, 0, 0, 0, 0, 1, 2, 3);
        frames(1, 12, "R9");
        for (int d = 0; d < 4; d++) begin
            do_load(0, 1, 0, 2'(d), 0, 0, 0, 1, 2, 3);
            frames(1, 10, "R1");
            do_load(0, 0, 1, 2'(d), 0, 0, 0, 1, 2, 3);
            frames(1, 10, "R9");
        end

        // R3 shared polynomial, line starts ignored (R6), each depth (R1)
        for (int d = 0; d < 4; d++) begin
            do_load(1, 0, 0, 2'(d), 0, 0, 0, 28'($urandom), 28'($urandom), 28'($urandom));
            frames(3, 9, "R3");
        end
        // R8 pixel right after load carries no noise
        do_load(1, 0, 0, 0, 0, 0, 0, 28'h0ABCDEF, 28'h1234567, 28'h7654321);
        pix(1, 1, 1, 12'h03F, 12'h020, 12'h001, "R8");
        frames(2, 6, "R8");

        // R4 per-channel taps
        do_load(1, 0, 0, 0, 0, 1, 0, 28'($urandom), 28'($urandom), 28'($urandom));
        frames(4, 10, "R4");

        // R5 zero seeds
        do_load(1, 0, 0, 0, 0, 1, 0, 28'd0, 28'd0, 28'd0);
        frames(2, 10, "R5");

        // R6 / R7 frame-random across counter wraps
        do_load(1, 0, 0, 1, 1, 0, 0, 28'($urandom), 28'($urandom), 28'($urandom));
        frames(20, 3, "R7");
        do_load(1, 0, 0, 2, 1, 1, 0, 28'($urandom), 28'($urandom), 28'($urandom));
        frames(9, 3, "R6");

        // R10 high-pass noise, with and without reseed
        do_load(1, 0, 0, 0, 0, 0, 1, 28'($urandom), 28'($urandom), 28'($urandom));
        frames(3, 8, "R10");
        do_load(1, 0, 0, 0, 1, 1, 1, 28'($urandom), 28'($urandom), 28'($urandom));
        frames(4, 5, "R10");

        // R2 saturation at full scale
        do_load(1, 0, 0, 0, 0, 0, 0, 28'hFFFFFFF, 28'h0FFFFFF, 28'h00000FF);
        pix(0, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 8; i++)
            pix(1, i == 0, i == 0, 12'hFFF, 12'hFFE, 12'hFC1, "R2");

        pix(0, 0, 0, 0, 0, 0, "R11");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule